// File: doc/BRIEF.md
# Configuration Request Engine for a PCIe Root Port

This block turns one processor configuration access into one configuration request toward the link, and reports how that request completed. Software uses a small word-addressed register bus. It sets a control word that selects one of four configuration request kinds, a 64-bit target address, write data and byte-lane enables. It then writes the start register. The engine presents the request to a link-side responder with a valid/ready handshake and waits for a completion. It latches the completion code and, for reads, the returned data. It then raises a sticky interrupt-status bit.

The low address word carries the packed configuration target: bus number in bits [27:20], device in [19:15], function in [14:12] and dword register offset in [11:2]. Sub-dword writes are expressed through the lane enables. A programmable cycle limit bounds how long the engine waits, so a silent responder cannot hang the processor. Register word indexes: 0 control, 1 status, 2 address low, 3 address high, 4 write data, 5 lane enables, 6 read data, 7 start, 8 interrupt status, 9 wait limit.

Top module: `cfg_pio_engine`

## Requirements
- R1: Control bits [3:0] select the request kind: 0x8 read type 0, 0x9 read type 1, 0xA write type 0, 0xB write type 1. `lnk_req_write` equals code bit 1 and `lnk_req_type1` equals code bit 0.
- R2: `lnk_req_addr` is {address-high word (index 3), address-low word (index 2) bits [31:2], 2'b00}, so the packed bus/device/function/offset passes unchanged and bits [1:0] are always driven as zero.
- R3: On a write, `lnk_req_data` is the write-data register (index 4) and `lnk_req_strb` is the lane-enable register (index 5) bits [3:0]. A write of N bytes at offset k uses enables ((1<<N)-1)<<k with data shifted left by 8*k. On a read, `lnk_req_strb` is 4'hF whatever the lane-enable register holds.
- R4: Writing 1 in bit 0 of the start register (index 7) launches a request. The start register reads 1 while the request is in flight and 0 once it completes. `lnk_req_valid` stays high with stable request fields until `lnk_req_ready`.
- R5: While a request is in flight, writes to the start, control, address, data, lane-enable and limit registers are ignored: no second request is issued and those registers read back unchanged.
- R6: The status register (index 1) holds the completion code in bits [9:7] and a 1 in bit 0, because every configuration request is non-posted. Codes 0 (success), 1 (unsupported request), 2 (retry) and 4 (completer abort) are kept as received. Any other received code is recorded as 4.
- R7: Read data arriving with a read completion is latched into the read-data register (index 6) in the same cycle the interrupt bit sets. Write completions leave that register unchanged.
- R8: Bit 0 of the interrupt-status register (index 8) and the `pio_irq` output set when a request completes. Writing 1 to bit 0 clears them, and a completion in the same cycle wins over the clear.
- R9: If no completion arrives within the number of cycles in the limit register (index 9, reset value 64), the request ends with code 4. A timed-out read loads all ones into the read-data register.
- R10: A launch with a control code outside 0x8 to 0xB issues no link request and completes on the next cycle with code 1.
- R11: Control bit 24 is driven on `lnk_req_nowin` during the request. This flag tells the link side to skip outbound address-window translation.
- R12: After reset, no request is pending. The start, status, read-data and interrupt registers read 0, and the limit register reads 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| lnk_req_valid | output | 1 | Request presented to the link side |
| lnk_req_ready | input | 1 | Link side accepts the request |
| lnk_req_write | output | 1 | 1 for a configuration write |
| lnk_req_type1 | output | 1 | 1 for a type-1 (downstream bus) request |
| lnk_req_nowin | output | 1 | Skip outbound address-window translation |
| lnk_req_addr | output | 64 | Target address, dword aligned |
| lnk_req_data | output | 32 | Write payload |
| lnk_req_strb | output | 4 | Byte-lane enables |
| lnk_cpl_valid | input | 1 | Completion arrives this cycle |
| lnk_cpl_status | input | 3 | Completion code |
| lnk_cpl_data | input | 32 | Completion read data |
| pio_irq | output | 1 | Sticky completion interrupt |

## Verification
A sequencer stuck in flight shows at once as a start register that never returns to 0 and an interrupt that never rises. The wait limit bounds how long that can go unseen. A lost lock on the programming registers shows at the next accepted handshake: the responder sees a request kind, address or lane set different from what was launched, or sees a second request. A wrong code mapping or a late data latch shows in the first status or read-data read after the start register clears.

// File: rtl/cfg_pio_pkg.sv
// Shared constants, register indexes and the completion-code mapping for
// the configuration request engine. Assumes a 32-bit register bus.
package cfg_pio_pkg;

    localparam int DW      = 32;
    localparam int STRB_W  = DW / 8;
    localparam int RIDX_W  = 4;
    localparam int CODE_W  = 3;
    localparam int KIND_W  = 4;

    localparam logic [RIDX_W-1:0] REG_CTRL  = 4'd0;
    localparam logic [RIDX_W-1:0] REG_STAT  = 4'd1;
    localparam logic [RIDX_W-1:0] REG_ALO   = 4'd2;
    localparam logic [RIDX_W-1:0] REG_AHI   = 4'd3;
    localparam logic [RIDX_W-1:0] REG_WDAT  = 4'd4;
    localparam logic [RIDX_W-1:0] REG_STRB  = 4'd5;
    localparam logic [RIDX_W-1:0] REG_RDAT  = 4'd6;
    localparam logic [RIDX_W-1:0] REG_START = 4'd7;
    localparam logic [RIDX_W-1:0] REG_IRQ   = 4'd8;
    localparam logic [RIDX_W-1:0] REG_LIMIT = 4'd9;

    localparam int NOWIN_BIT = 24;

    localparam logic [CODE_W-1:0] CODE_OK    = 3'd0;
    localparam logic [CODE_W-1:0] CODE_UR    = 3'd1;
    localparam logic [CODE_W-1:0] CODE_RETRY = 3'd2;
    localparam logic [CODE_W-1:0] CODE_ABORT = 3'd4;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_t;

    // Keep the four defined codes, fold anything else into completer abort.
    function automatic logic [CODE_W-1:0] fold_code(input logic [CODE_W-1:0] raw);
        case (raw)
            CODE_OK, CODE_UR, CODE_RETRY, CODE_ABORT: fold_code = raw;
            default:                                  fold_code = CODE_ABORT;
        endcase
    endfunction

endpackage

// File: rtl/cfg_pio_regs.sv
// Software-visible register file of the request engine.
// Holds the programming registers, locks them while a request is in flight,
// records the completion code and read data, and keeps the sticky interrupt.
// Assumes 'fin' is a single-cycle pulse from the sequencer.
module cfg_pio_regs
    import cfg_pio_pkg::*;
#(
    parameter int TO_W        = 16,
    parameter int DEF_TIMEOUT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [RIDX_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              busy,
    input  logic              fin,
    input  logic              fin_read,
    input  logic [CODE_W-1:0] fin_code,
    input  logic [DW-1:0]     fin_data,
    output logic              launch,
    output logic [KIND_W-1:0] ctrl_kind,
    output logic              ctrl_nowin,
    output logic [DW-1:0]     addr_lo_q,
    output logic [DW-1:0]     addr_hi_q,
    output logic [DW-1:0]     wdat_q,
    output logic [STRB_W-1:0] strb_q,
    output logic [TO_W-1:0]   limit_q,
    output logic [CODE_W-1:0] stat_code,
    output logic              irq_q
);

    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] rdat_q;
    logic          np_q;
    logic [DW-1:0] stat_word;

    assign ctrl_kind  = ctrl_q[KIND_W-1:0];
    assign ctrl_nowin = ctrl_q[NOWIN_BIT];

    // Launch only when idle and bit 0 of the start write is set.
    assign launch = bus_wr_en && (bus_addr == REG_START) && bus_wdata[0] && !busy;

    // Programming registers: written only while no request is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            wdat_q    <= '0;
            strb_q    <= '0;
            limit_q   <= TO_W'(DEF_TIMEOUT);
        end else if (bus_wr_en && !busy) begin
            case (bus_addr)
                REG_CTRL:  ctrl_q    <= bus_wdata;
                REG_ALO:   addr_lo_q <= bus_wdata;
                REG_AHI:   addr_hi_q <= bus_wdata;
                REG_WDAT:  wdat_q    <= bus_wdata;
                REG_STRB:  strb_q    <= bus_wdata[STRB_W-1:0];
                REG_LIMIT: limit_q   <= bus_wdata[TO_W-1:0];
                default:   ;
            endcase
        end
    end

    // Completion results: code, non-posted flag and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_code <= CODE_OK;
            np_q      <= 1'b0;
            rdat_q    <= '0;
        end else if (fin) begin
            stat_code <= fin_code;
            np_q      <= 1'b1;
            if (fin_read) begin
                rdat_q <= fin_data;
            end
        end
    end

    // Sticky interrupt: completion sets it, write-one clears it, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (fin) begin
            irq_q <= 1'b1;
        end else if (bus_wr_en && (bus_addr == REG_IRQ) && bus_wdata[0]) begin
            irq_q <= 1'b0;
        end
    end

    // Status word layout: code in [9:7], non-posted flag in [0].
    always_comb begin
        stat_word      = '0;
        stat_word[9:7] = stat_code;
        stat_word[0]   = np_q;
    end

    // Read-back multiplexer.
    always_comb begin
        case (bus_addr)
            REG_CTRL:  bus_rdata = ctrl_q;
            REG_STAT:  bus_rdata = stat_word;
            REG_ALO:   bus_rdata = addr_lo_q;
            REG_AHI:   bus_rdata = addr_hi_q;
            REG_WDAT:  bus_rdata = wdat_q;
            REG_STRB:  bus_rdata = {{(DW-STRB_W){1'b0}}, strb_q};
            REG_RDAT:  bus_rdata = rdat_q;
            REG_START: bus_rdata = {{(DW-1){1'b0}}, busy};
            REG_IRQ:   bus_rdata = {{(DW-1){1'b0}}, irq_q};
            REG_LIMIT: bus_rdata = {{(DW-TO_W){1'b0}}, limit_q};
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cfg_pio_req_build.sv
// Decodes the request kind and shapes the outgoing request fields.
// Purely combinational. Assumes the inputs are held stable while in flight.
module cfg_pio_req_build
    import cfg_pio_pkg::*;
(
    input  logic [KIND_W-1:0] ctrl_kind,
    input  logic [DW-1:0]     addr_lo,
    input  logic [DW-1:0]     addr_hi,
    input  logic [DW-1:0]     wdat,
    input  logic [STRB_W-1:0] strb,
    output logic              kind_ok,
    output logic              is_write,
    output logic              is_type1,
    output logic [2*DW-1:0]   req_addr,
    output logic [DW-1:0]     req_data,
    output logic [STRB_W-1:0] req_strb
);

    // Kind decode: only the four configuration codes are legal.
    always_comb begin
        kind_ok  = 1'b0;
        is_write = 1'b0;
        is_type1 = 1'b0;
        case (ctrl_kind)
            4'h8: begin kind_ok = 1'b1; end
            4'h9: begin kind_ok = 1'b1; is_type1 = 1'b1; end
            4'hA: begin kind_ok = 1'b1; is_write = 1'b1; end
            4'hB: begin kind_ok = 1'b1; is_write = 1'b1; is_type1 = 1'b1; end
            default: ;
        endcase
    end

    // Dword-aligned target address.
    assign req_addr = {addr_hi, addr_lo[DW-1:2], 2'b00};
    assign req_data = wdat;

    // Per-lane enable: writes use software enables, reads use every lane.
    for (genvar ln = 0; ln < STRB_W; ln++) begin : g_lane
        assign req_strb[ln] = is_write ? strb[ln] : 1'b1;
    end

endmodule

// File: rtl/cfg_pio_seq.sv
// Request sequencer: issues one request, waits for its completion, and
// enforces the programmable wait limit. Emits a one-cycle 'fin' pulse with
// the folded completion code and the data to latch.
// Assumes 'launch' is only asserted while idle.
module cfg_pio_seq
    import cfg_pio_pkg::*;
#(
    parameter int TO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              kind_ok,
    input  logic              req_ready,
    input  logic              cpl_valid,
    input  logic [CODE_W-1:0] cpl_status,
    input  logic [DW-1:0]     cpl_data,
    input  logic [TO_W-1:0]   limit,
    output logic              busy,
    output logic              req_valid,
    output logic              fin,
    output logic [CODE_W-1:0] fin_code,
    output logic [DW-1:0]     fin_data
);

    seq_state_t          state_q, state_d;
    logic [TO_W-1:0]     cnt_q, cnt_d;
    logic                hit;

    assign busy      = (state_q != SEQ_IDLE);
    assign req_valid = (state_q == SEQ_ISSUE);

    // Limit reached when this in-flight cycle is the last one allowed.
    assign hit = (({1'b0, cnt_q} + (TO_W+1)'(1)) >= {1'b0, limit});

    // Next-state and completion decision.
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        fin      = 1'b0;
        fin_code = CODE_OK;
        fin_data = cpl_data;
        case (state_q)
            SEQ_IDLE: begin
                if (launch) begin
                    cnt_d = '0;
                    if (kind_ok) begin
                        state_d = SEQ_ISSUE;
                    end else begin
                        fin      = 1'b1;
                        fin_code = CODE_UR;
                    end
                end
            end
            SEQ_ISSUE: begin
                if (hit) begin
                    fin      = 1'b1;
                    fin_code = CODE_ABORT;
                    fin_data = '1;
                    state_d  = SEQ_IDLE;
                end else begin
                    cnt_d = cnt_q + TO_W'(1);
                    if (req_ready) begin
                        state_d = SEQ_WAIT;
                    end
                end
            end
            SEQ_WAIT: begin
                if (cpl_valid) begin
                    fin      = 1'b1;
                    fin_code = fold_code(cpl_status);
                    state_d  = SEQ_IDLE;
                end else if (hit) begin
                    fin      = 1'b1;
                    fin_code = CODE_ABORT;
                    fin_data = '1;
                    state_d  = SEQ_IDLE;
                end else begin
                    cnt_d = cnt_q + TO_W'(1);
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // State and wait-counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/cfg_pio_engine.sv
// Top of the configuration request engine: register file, request shaping
// and sequencer. One request at a time; the link side returns at most one
// completion per accepted request.
module cfg_pio_engine
    import cfg_pio_pkg::*;
#(
    parameter int TO_W        = 16,
    parameter int DEF_TIMEOUT = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr_en,
    input  logic [3:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          lnk_req_valid,
    input  logic          lnk_req_ready,
    output logic          lnk_req_write,
    output logic          lnk_req_type1,
    output logic          lnk_req_nowin,
    output logic [63:0]   lnk_req_addr,
    output logic [31:0]   lnk_req_data,
    output logic [3:0]    lnk_req_strb,
    input  logic          lnk_cpl_valid,
    input  logic [2:0]    lnk_cpl_status,
    input  logic [31:0]   lnk_cpl_data,
    output logic          pio_irq
);

    logic              busy, launch, fin, kind_ok;
    logic [CODE_W-1:0] fin_code, stat_code;
    logic [DW-1:0]     fin_data;
    logic [KIND_W-1:0] ctrl_kind;
    logic              ctrl_nowin;
    logic [DW-1:0]     addr_lo_q, addr_hi_q, wdat_q;
    logic [STRB_W-1:0] strb_q;
    logic [TO_W-1:0]   limit_q;

    cfg_pio_regs #(.TO_W(TO_W), .DEF_TIMEOUT(DEF_TIMEOUT)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .fin       (fin),
        .fin_read  (kind_ok && !lnk_req_write),
        .fin_code  (fin_code),
        .fin_data  (fin_data),
        .launch    (launch),
        .ctrl_kind (ctrl_kind),
        .ctrl_nowin(ctrl_nowin),
        .addr_lo_q (addr_lo_q),
        .addr_hi_q (addr_hi_q),
        .wdat_q    (wdat_q),
        .strb_q    (strb_q),
        .limit_q   (limit_q),
        .stat_code (stat_code),
        .irq_q     (pio_irq)
    );

    cfg_pio_req_build build_i (
        .ctrl_kind(ctrl_kind),
        .addr_lo  (addr_lo_q),
        .addr_hi  (addr_hi_q),
        .wdat     (wdat_q),
        .strb     (strb_q),
        .kind_ok  (kind_ok),
        .is_write (lnk_req_write),
        .is_type1 (lnk_req_type1),
        .req_addr (lnk_req_addr),
        .req_data (lnk_req_data),
        .req_strb (lnk_req_strb)
    );

    cfg_pio_seq #(.TO_W(TO_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .kind_ok   (kind_ok),
        .req_ready (lnk_req_ready),
        .cpl_valid (lnk_cpl_valid),
        .cpl_status(lnk_cpl_status),
        .cpl_data  (lnk_cpl_data),
        .limit     (limit_q),
        .busy      (busy),
        .req_valid (lnk_req_valid),
        .fin       (fin),
        .fin_code  (fin_code),
        .fin_data  (fin_data)
    );

    assign lnk_req_nowin = ctrl_nowin;

endmodule

// File: rtl/cfg_pio_chk.sv
// Protocol checker for the configuration request engine, bound to the top.
// Watches the link handshake, register locking, completion reporting and
// the wait-limit window.
module cfg_pio_chk #(
    parameter int TO_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            launch,
    input logic            kind_ok,
    input logic            fin,
    input logic            pio_irq,
    input logic [2:0]      stat_code,
    input logic [TO_W-1:0] limit_q,
    input logic [3:0]      ctrl_kind,
    input logic            ctrl_nowin,
    input logic            lnk_req_valid,
    input logic            lnk_req_ready,
    input logic            lnk_req_write,
    input logic [63:0]     lnk_req_addr,
    input logic [31:0]     lnk_req_data,
    input logic [3:0]      lnk_req_strb
);

    logic [TO_W:0] win_cnt;

    // Counts cycles spent in flight since launch.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            win_cnt <= '0;
        end else begin
            win_cnt <= win_cnt + (TO_W+1)'(1);
        end
    end

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_req_valid && !lnk_req_ready |=> $stable(lnk_req_addr) && $stable(lnk_req_data)
                                          && $stable(lnk_req_strb) && $stable(lnk_req_write));

    // R4
    req_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_req_valid |-> busy);

    // R5
    ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctrl_kind) && $stable(ctrl_nowin) && $stable(limit_q));

    // R6
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> $onehot0(stat_code));

    // R8
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> pio_irq);

    // R9
    wait_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (limit_q != '0) |-> (win_cnt < {1'b0, limit_q}));

    // R10
    bad_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch && !kind_ok |=> !busy && !lnk_req_valid && pio_irq);

endmodule

bind cfg_pio_engine cfg_pio_chk #(.TO_W(TO_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .launch       (launch),
    .kind_ok      (kind_ok),
    .fin          (fin),
    .pio_irq      (pio_irq),
    .stat_code    (stat_code),
    .limit_q      (limit_q),
    .ctrl_kind    (ctrl_kind),
    .ctrl_nowin   (ctrl_nowin),
    .lnk_req_valid(lnk_req_valid),
    .lnk_req_ready(lnk_req_ready),
    .lnk_req_write(lnk_req_write),
    .lnk_req_addr (lnk_req_addr),
    .lnk_req_data (lnk_req_data),
    .lnk_req_strb (lnk_req_strb)
);

// File: tb/cfg_pio_engine_tb_top.sv
// Scoreboard bench: the driver queues the expected link request, the
// responder stub pops and compares at each handshake, and the driver
// checks the register-visible results.
module cfg_pio_engine_tb_top;
    import cfg_pio_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        lnk_req_valid, lnk_req_write, lnk_req_type1, lnk_req_nowin;
    logic        lnk_req_ready = 1'b0;
    logic [63:0] lnk_req_addr;
    logic [31:0] lnk_req_data;
    logic [3:0]  lnk_req_strb;
    logic        lnk_cpl_valid = 1'b0;
    logic [2:0]  lnk_cpl_status = '0;
    logic [31:0] lnk_cpl_data = '0;
    logic        pio_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    // Responder settings, set by the driver per request.
    int          ready_delay = 0;
    int          cpl_delay = 1;
    bit          silent = 0;
    logic [2:0]  resp_code = '0;
    logic [31:0] resp_data = '0;
    int          hs_count = 0;
    logic [31:0] last_rd = '0;

    // Expected request: {write, type1, nowin, addr, data, strb}.
    logic [102:0] exp_q[$];

    always #2 clk = ~clk;

    cfg_pio_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lnk_req_valid(lnk_req_valid), .lnk_req_ready(lnk_req_ready),
        .lnk_req_write(lnk_req_write), .lnk_req_type1(lnk_req_type1), .lnk_req_nowin(lnk_req_nowin),
        .lnk_req_addr(lnk_req_addr), .lnk_req_data(lnk_req_data), .lnk_req_strb(lnk_req_strb),
        .lnk_cpl_valid(lnk_cpl_valid), .lnk_cpl_status(lnk_cpl_status), .lnk_cpl_data(lnk_cpl_data),
        .pio_irq(pio_irq)
    );

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle(output int polls);
        logic [31:0] v;
        polls = 0;
        for (int i = 0; i < 2000; i++) begin
            reg_read(REG_START, v);
            polls++;
            if (v == 32'd0) break;
        end
    endtask

    // Responder stub and monitor: grants ready, compares the request, answers.
    initial begin
        int  rd_cnt;
        int  cd;
        bit  pend;
        logic [102:0] e;
        rd_cnt = 0; cd = 0; pend = 0;
        forever begin
            @(negedge clk);
            lnk_cpl_valid = 1'b0;
            if (pend) begin
                if (cd == 0) begin
                    lnk_cpl_valid = 1'b1; lnk_cpl_status = resp_code; lnk_cpl_data = resp_data; pend = 0;
                end else cd--;
            end
            if (lnk_req_ready) begin
                lnk_req_ready = 1'b0;
                if (!silent) begin pend = 1; cd = cpl_delay; end
            end else if (lnk_req_valid) begin
                if (rd_cnt >= ready_delay) begin
                    lnk_req_ready = 1'b1; rd_cnt = 0; hs_count++;
                    if (exp_q.size() == 0) begin
                        check("R4", "unexpected request", 64'd1, 64'd0);
                    end else begin
                        e = exp_q.pop_front();
                        check("R1", "write flag", 64'(lnk_req_write), 64'(e[102]));
                        check("R1", "type1 flag", 64'(lnk_req_type1), 64'(e[101]));
                        check("R11", "nowin flag", 64'(lnk_req_nowin), 64'(e[100]));
                        check("R2", "address", lnk_req_addr, e[99:36]);
                        if (e[102]) check("R3", "write data", 64'(lnk_req_data), 64'(e[35:4]));
                        check("R3", "lane enables", 64'(lnk_req_strb), 64'(e[3:0]));
                    end
                end else rd_cnt++;
            end else rd_cnt = 0;
        end
    end

    // Driver: program, queue expectation, launch, then check the results.
    task automatic run_req(input string req, input logic [3:0] kind, input logic [31:0] alo,
                           input logic [31:0] ahi, input logic [31:0] wd, input logic [3:0] st,
                           input bit nowin, input logic [2:0] rcode, input logic [31:0] rdat,
                           input logic [2:0] exp_code);
        logic [31:0] v;
        int polls, hs0;
        bit legal, wr;
        legal = (kind >= 4'h8) && (kind <= 4'hB);
        wr = kind[1];
        reg_write(REG_CTRL, {7'd0, nowin, 20'd0, kind});
        reg_write(REG_ALO, alo);
        reg_write(REG_AHI, ahi);
        reg_write(REG_WDAT, wd);
        reg_write(REG_STRB, {28'd0, st});
        resp_code = rcode; resp_data = rdat;
        if (legal)
            exp_q.push_back({wr, kind[0], nowin, ahi, alo[31:2], 2'b00, (wr ? wd : 32'd0), (wr ? st : 4'hF)});
        hs0 = hs_count;
        reg_write(REG_START, 32'd1);
        wait_idle(polls);
        check(req, "request count", 64'(hs_count - hs0), legal ? 64'd1 : 64'd0);
        reg_read(REG_STAT, v);
        check({req, " R6"}, "status word", 64'(v), 64'((32'(exp_code) << 7) | 32'd1));
        if (legal && !wr) last_rd = (exp_code == CODE_ABORT && silent) ? 32'hFFFF_FFFF : rdat;
        reg_read(REG_RDAT, v);
        check("R7", "read data", 64'(v), 64'(last_rd));
        check("R8", "irq after done", 64'(pio_irq), 64'd1);
        reg_read(REG_IRQ, v);
        check("R8", "irq register", 64'(v), 64'd1);
        reg_write(REG_IRQ, 32'd1);
        #1 check("R8", "irq after clear", 64'(pio_irq), 64'd0);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int polls, hs0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        reg_read(REG_START, v); check("R12", "start reg", 64'(v), 64'd0);
        reg_read(REG_STAT, v);  check("R12", "status reg", 64'(v), 64'd0);
        reg_read(REG_RDAT, v);  check("R12", "read data reg", 64'(v), 64'd0);
        reg_read(REG_IRQ, v);   check("R12", "irq reg", 64'(v), 64'd0);
        reg_read(REG_LIMIT, v); check("R12", "limit reg", 64'(v), 64'd64);
        check("R12", "no request", 64'(lnk_req_valid), 64'd0);

        // R1 R2 R3 type-0 read, bus 0 dev 0 fn 0 offset 0x10, lane reg ignored
        run_req("R1", 4'h8, 32'h0000_0010, 32'd0, 32'hDEAD_BEEF, 4'h3, 1'b0, CODE_OK, 32'h1234_5678, CODE_OK);
        // R1 R2 type-1 read bus 5 dev 3 fn 2 offset 0x44, low bits forced zero, UR code
        run_req("R2", 4'h9, (32'd5 << 20) | (32'd3 << 15) | (32'd2 << 12) | 32'h47, 32'h0000_0001,
                32'd0, 4'h0, 1'b1, CODE_UR, 32'hCAFE_0001, CODE_UR);
        // R3 type-0 byte write at offset 2: enables 0x4, data shifted by 16, retry code
        run_req("R3", 4'hA, 32'h0000_0100, 32'd0, 32'h00AB_0000, 4'h4, 1'b0, CODE_RETRY, 32'h0, CODE_RETRY);
        // R3 R11 type-1 halfword write at offset 2, nowin set, abort code
        run_req("R11", 4'hB, (32'd1 << 20) | 32'h200, 32'd0, 32'h5A5A_0000, 4'hC, 1'b1, CODE_ABORT, 32'h0, CODE_ABORT);
        // R6 undefined completion code 3 recorded as abort
        run_req("R6", 4'h8, 32'h0000_0008, 32'd0, 32'd0, 4'hF, 1'b0, 3'd3, 32'h0BAD_C0DE, CODE_ABORT);
        // R10 illegal kind: no request, code 1
        run_req("R10", 4'h3, 32'h0000_0020, 32'd0, 32'd0, 4'hF, 1'b0, CODE_OK, 32'h0, CODE_UR);

        // R9 silent responder with limit 20: read ends with abort and all ones
        reg_write(REG_LIMIT, 32'd20);
        silent = 1;
        reg_write(REG_CTRL, 32'h0000_0008);
        reg_write(REG_ALO, 32'h0000_0030);
        exp_q.push_back({1'b0, 1'b0, 1'b0, 32'd0, 30'(32'h30 >> 2), 2'b00, 32'd0, 4'hF});
        reg_write(REG_START, 32'd1);
        wait_idle(polls);
        n_chk++;
        if (polls < 20 || polls > 22) begin
            n_fail++;
            $display("FAIL R9 wait length actual=%0d expected=20..22", polls);
        end
        reg_read(REG_STAT, v); check("R9", "timeout status", 64'(v), 64'((32'd4 << 7) | 32'd1));
        reg_read(REG_RDAT, v); check("R9", "timeout read data", 64'(v), 64'hFFFF_FFFF);
        last_rd = 32'hFFFF_FFFF;
        reg_write(REG_IRQ, 32'd1);
        silent = 0;
        reg_write(REG_LIMIT, 32'd64);

        // R4 R5 slow responder: busy readback and writes during flight ignored
        ready_delay = 6; cpl_delay = 8;
        reg_write(REG_CTRL, 32'h0000_000A);
        reg_write(REG_ALO, 32'h0000_0040);
        reg_write(REG_WDAT, 32'h1111_2222);
        reg_write(REG_STRB, 32'hF);
        resp_code = CODE_OK;
        exp_q.push_back({1'b1, 1'b0, 1'b0, 32'd0, 30'(32'h40 >> 2), 2'b00, 32'h1111_2222, 4'hF});
        hs0 = hs_count;
        reg_write(REG_START, 32'd1);
        reg_read(REG_START, v); check("R4", "start reads busy", 64'(v), 64'd1);
        reg_write(REG_CTRL, 32'h0000_0009);
        reg_write(REG_ALO, 32'h0000_0080);
        reg_write(REG_WDAT, 32'h3333_4444);
        reg_write(REG_START, 32'd1);
        wait_idle(polls);
        check("R5", "single request", 64'(hs_count - hs0), 64'd1);
        reg_read(REG_CTRL, v); check("R5", "control unchanged", 64'(v), 64'h0000_000A);
        reg_read(REG_ALO, v);  check("R5", "address unchanged", 64'(v), 64'h0000_0040);
        reg_read(REG_WDAT, v); check("R5", "data unchanged", 64'(v), 64'h1111_2222);
        reg_read(REG_START, v); check("R4", "start clear after done", 64'(v), 64'd0);
        reg_write(REG_IRQ, 32'd1);
        repeat (4) @(negedge clk);
        check("R4", "queue drained", 64'(exp_q.size()), 64'd0);

        done_flag = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule